// File: doc/BRIEF.md
# Replaying Stream Transmit Channel

This block is a single transmit channel that feeds a 128-bit AXI4-Stream master port toward a compute fabric. Before a run, a control agent fills a local beat buffer through a plain write port, one 128-bit word per address. It then presents a byte count, a start delay and a pass count, and pulses `start`. The channel captures this setup, waits out the delay in clock cycles and then streams the buffered words in address order.

A run can repeat the whole dataset several times. If the requested size per pass is larger than the buffer, the channel sends the whole buffer and then fills the rest of the pass with pseudo-random words from a 32-bit LFSR. While it streams, the channel times the run, including the cycles in which the sink holds off `m_tready`. A `done` flag reports completion and keeps the measured latency readable until the next start.

Top module: `tx_replay_channel`

## Requirements
- R1: After reset `m_tvalid`, `done` and `busy` are low and `latency` reads 0.
- R2: When the channel is not busy, a write on the preload port stores the 128-bit `wr_data` at `wr_addr`. Each pass streams buffer words in order, starting from address 0.
- R3: With a captured delay D, the first `m_tvalid` appears D cycles after the clock edge that samples `start`. With D = 0 it appears right after that edge.
- R4: Each pass has `cfg_bytes >> 4` beats. Bits [3:0] of `cfg_bytes` are ignored.
- R5: `cfg_passes` sets how many times the dataset is sent, and every pass restarts at buffer address 0. A value of 0 behaves as 1.
- R6: `m_tlast` is high on the final beat of every pass and on no other beat.
- R7: Beat index i of a pass, for i >= DEPTH, carries the pad word {4{s}}. s is a Galois right-shift LFSR: next = (s >> 1) XOR (s[0] ? 32'h80200003 : 0). It is loaded with SEED (default 32'h00000001) at start, the first pad beat carries SEED, and the LFSR advances on each accepted pad beat without reloading between passes.
- R8: Once `m_tvalid` is high, it stays high and `m_tdata` and `m_tlast` stay unchanged until `m_tready` accepts the beat.
- R9: `latency` equals the number of clock edges from the first accepted beat to the last accepted beat, stall cycles included. A run of one beat reads 0.
- R10: `done` goes high in the cycle after the last accepted beat. `done` and `latency` then hold until the next accepted `start`.
- R11: A byte count below 16 sends no beat. `done` rises D cycles after start and `latency` reads 0.
- R12: While `busy` is high, preload writes and `start` pulses have no effect on the buffer or on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Preload write strobe |
| wr_addr | input | AW | Preload word address |
| wr_data | input | 128 | Preload word |
| start | input | 1 | Launch pulse, captures the setup |
| cfg_bytes | input | SIZE_W | Bytes per pass (multiple of 16) |
| cfg_delay | input | DLY_W | Start delay in cycles |
| cfg_passes | input | RPL_W | Number of passes (0 means 1) |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 128 | Stream beat data |
| m_tlast | output | 1 | Final beat of a pass |
| busy | output | 1 | Delay countdown or streaming in progress |
| done | output | 1 | Run complete |
| latency | output | LAT_W | Cycles from first to last accepted beat |

## Verification
The tightest case is the boundary between buffer and pad beats, where a beat's source changes in the same cycle that the sink stalls. The bench uses a pass of DEPTH+3 beats over two passes with a periodic `m_tready` pattern, so the first pad beat, which must carry SEED, is held through stalls. The pass-end restart to address 0 then follows a pad beat. A scoreboard predicts every beat and every `tlast` from its own buffer image and its own LFSR model. A second overlap is a write and a `start` that arrive during the delay countdown; both must be ignored, and a later run that reads address 0 shows this.

// File: rtl/tx_chan_pkg.sv
package tx_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2,
        ST_DONE = 2'd3
    } tx_state_e;

    localparam logic [31:0] TX_PRNG_MASK = 32'h8020_0003;

    function automatic logic [31:0] prng_next(input logic [31:0] s);
        return {1'b0, s[31:1]} ^ (s[0] ? TX_PRNG_MASK : 32'h0);
    endfunction

endpackage

// File: rtl/tx_beat_store.sv
module tx_beat_store #(
    parameter int DATA_W = 128,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/tx_prng.sv
module tx_prng
    import tx_chan_pkg::*;
#(
    parameter logic [31:0] SEED = 32'h0000_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic        step,
    output logic [31:0] word
);

    logic [31:0] s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d = SEED;
        end else if (step) begin
            s_d = prng_next(s_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SEED;
        end else begin
            s_q <= s_d;
        end
    end

    assign word = s_q;

endmodule

// File: rtl/tx_sequencer.sv
module tx_sequencer
    import tx_chan_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int BEAT_W = 28,
    parameter int DLY_W  = 16,
    parameter int RPL_W  = 8,
    parameter int LAT_W  = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BEAT_W-1:0] cfg_beats,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic [RPL_W-1:0]  cfg_passes,
    input  logic              tready,
    output logic              tvalid,
    output logic              tlast,
    output logic              use_pad,
    output logic [AW-1:0]     rd_addr,
    output logic              pad_load,
    output logic              pad_step,
    output logic              busy,
    output logic              done,
    output logic [LAT_W-1:0]  latency
);

    typedef struct packed {
        tx_state_e         st;
        logic [DLY_W-1:0]  dly;
        logic [BEAT_W-1:0] beat;
        logic [BEAT_W-1:0] nbeats;
        logic [RPL_W-1:0]  pass;
        logic [RPL_W-1:0]  npass;
        logic              timing;
        logic [LAT_W-1:0]  lat;
    } seq_t;

    seq_t n_d, n_q;

    logic idle_like, accept, hs, beat_end, pass_end;

    always_comb begin
        idle_like = (n_q.st == ST_IDLE) || (n_q.st == ST_DONE);
        accept    = idle_like && start;
        hs        = (n_q.st == ST_SEND) && tready;
        beat_end  = n_q.beat == (n_q.nbeats - BEAT_W'(1));
        pass_end  = n_q.pass == (n_q.npass - RPL_W'(1));
        use_pad   = n_q.beat >= BEAT_W'(DEPTH);

        n_d = n_q;
        unique case (n_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    n_d.nbeats = cfg_beats;
                    n_d.npass  = (cfg_passes == '0) ? RPL_W'(1) : cfg_passes;
                    n_d.beat   = '0;
                    n_d.pass   = '0;
                    n_d.lat    = '0;
                    n_d.timing = 1'b0;
                    n_d.dly    = cfg_delay;
                    if (cfg_delay != '0)       n_d.st = ST_WAIT;
                    else if (cfg_beats == '0)  n_d.st = ST_DONE;
                    else                       n_d.st = ST_SEND;
                end
            end
            ST_WAIT: begin
                if (n_q.dly == DLY_W'(1)) begin
                    n_d.st = (n_q.nbeats == '0) ? ST_DONE : ST_SEND;
                end else begin
                    n_d.dly = n_q.dly - DLY_W'(1);
                end
            end
            ST_SEND: begin
                if (n_q.timing) begin
                    n_d.lat = n_q.lat + LAT_W'(1);
                end
                if (hs) begin
                    if ((n_q.beat == '0) && (n_q.pass == '0)) begin
                        n_d.timing = 1'b1;
                        n_d.lat    = '0;
                    end
                    if (beat_end) begin
                        n_d.beat = '0;
                        if (pass_end) begin
                            n_d.st     = ST_DONE;
                            n_d.timing = 1'b0;
                        end else begin
                            n_d.pass = n_q.pass + RPL_W'(1);
                        end
                    end else begin
                        n_d.beat = n_q.beat + BEAT_W'(1);
                    end
                end
            end
            default: n_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= '{st: ST_IDLE, default: '0};
        end else begin
            n_q <= n_d;
        end
    end

    assign tvalid   = n_q.st == ST_SEND;
    assign tlast    = tvalid && beat_end;
    assign rd_addr  = n_q.beat[AW-1:0];
    assign pad_load = accept;
    assign pad_step = hs && use_pad;
    assign busy     = (n_q.st == ST_WAIT) || (n_q.st == ST_SEND);
    assign done     = n_q.st == ST_DONE;
    assign latency  = n_q.lat;

endmodule

// File: rtl/tx_replay_channel.sv
module tx_replay_channel #(
    parameter int          DATA_W = 128,
    parameter int          DEPTH  = 256,
    parameter int          SIZE_W = 32,
    parameter int          DLY_W  = 16,
    parameter int          RPL_W  = 8,
    parameter int          LAT_W  = 32,
    parameter logic [31:0] SEED   = 32'h0000_0001,
    localparam int         AW     = $clog2(DEPTH),
    localparam int         BYTE_SH = $clog2(DATA_W / 8),
    localparam int         BEAT_W = SIZE_W - BYTE_SH,
    localparam int         LANES  = DATA_W / 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start,
    input  logic [SIZE_W-1:0] cfg_bytes,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic [RPL_W-1:0]  cfg_passes,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tlast,
    output logic              busy,
    output logic              done,
    output logic [LAT_W-1:0]  latency
);

    logic              use_pad, pad_load, pad_step;
    logic [AW-1:0]     rd_addr;
    logic [DATA_W-1:0] buf_word, pad_wide;
    logic [31:0]       pad_word;

    tx_beat_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en && !busy),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (buf_word)
    );

    tx_prng #(.SEED(SEED)) u_prng (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pad_load),
        .step  (pad_step),
        .word  (pad_word)
    );

    tx_sequencer #(
        .DEPTH(DEPTH), .BEAT_W(BEAT_W), .DLY_W(DLY_W),
        .RPL_W(RPL_W), .LAT_W(LAT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_beats  (cfg_bytes[SIZE_W-1:BYTE_SH]),
        .cfg_delay  (cfg_delay),
        .cfg_passes (cfg_passes),
        .tready     (m_tready),
        .tvalid     (m_tvalid),
        .tlast      (m_tlast),
        .use_pad    (use_pad),
        .rd_addr    (rd_addr),
        .pad_load   (pad_load),
        .pad_step   (pad_step),
        .busy       (busy),
        .done       (done),
        .latency    (latency)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_pad_lane
        assign pad_wide[g*32 +: 32] = pad_word;
    end

    assign m_tdata = use_pad ? pad_wide : buf_word;

endmodule

// File: rtl/tx_replay_channel_chk.sv
module tx_replay_channel_chk #(
    parameter int DATA_W = 128,
    parameter int LAT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic [DATA_W-1:0] m_tdata,
    input logic              m_tlast,
    input logic              busy,
    input logic              done,
    input logic [LAT_W-1:0]  latency
);

    // R8: a presented beat holds until accepted
    assert_beat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

    // R6: the pass marker only rides on a valid beat
    assert_last_on_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> m_tvalid);

    // R10: completion and its measurement persist until a new start
    assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(latency));

    // R3: beats only appear while the channel is active
    assert_valid_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> busy && !done);

    // R12: activity and completion never overlap
    assert_busy_not_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

endmodule

bind tx_replay_channel tx_replay_channel_chk #(.DATA_W(DATA_W), .LAT_W(LAT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tdata  (m_tdata),
    .m_tlast  (m_tlast),
    .busy     (busy),
    .done     (done),
    .latency  (latency)
);

// File: tb/tx_replay_channel_tb.sv
module tx_replay_channel_tb;

    localparam int          DEPTH = 16;
    localparam int          AW    = $clog2(DEPTH);
    localparam logic [31:0] SEED  = 32'h0000_0001;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [127:0] wr_data = '0;
    logic         start = 1'b0;
    logic [31:0]  cfg_bytes = '0;
    logic [15:0]  cfg_delay = '0;
    logic [7:0]   cfg_passes = '0;
    logic         m_tvalid, m_tready, m_tlast, busy, done;
    logic [127:0] m_tdata;
    logic [31:0]  latency;

    always #5 clk = ~clk;

    tx_replay_channel #(.DEPTH(DEPTH), .SEED(SEED)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .cfg_bytes(cfg_bytes), .cfg_delay(cfg_delay), .cfg_passes(cfg_passes),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast),
        .busy(busy), .done(done), .latency(latency)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int stall_mode = 0;
    int seen = 0;
    int first_cyc = -1;
    int last_cyc = -1;
    logic [127:0] model_mem [DEPTH];
    logic [128:0] exp_q [$];

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lfsr_adv(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
    endfunction

    function automatic logic [127:0] pattern(input int i, input int k);
        return {32'hA000_0000 + i + k, 32'hB100_0000 ^ (i * 7), ~(32'h0 + i), 32'h5A5A_0000 + k};
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // sink ready pattern
    always @(negedge clk) begin
        case (stall_mode)
            0: m_tready = 1'b1;
            1: m_tready = (cyc % 3) != 0;
            default: m_tready = (cyc % 5) > 1;
        endcase
    end

    // monitor: pops the scoreboard on each handshake
    always @(negedge clk) begin
        #4;
        if (rst_n && m_tvalid && m_tready) begin
            logic [128:0] e;
            if (first_cyc < 0) first_cyc = cyc;
            last_cyc = cyc;
            seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected beat", m_tdata, '0);
            end else begin
                e = exp_q.pop_front();
                check(m_tdata == e[127:0], "R2/R7 beat data", m_tdata, e[127:0]);
                check(m_tlast == e[128], "R6 tlast", {127'b0, m_tlast}, {127'b0, e[128]});
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic preload(input int k);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = AW'(i); wr_data = pattern(i, k);
            model_mem[i] = pattern(i, k);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: pushes expected beats, launches, measures delay and completion
    task automatic run(input logic [31:0] bytes, input int dly, input int passes,
                       input bit disturb, input string tag);
        int nb, np, cnt;
        logic [31:0] s;
        nb = int'(bytes >> 4);
        np = (passes == 0) ? 1 : passes;
        s = SEED;
        for (int p = 0; p < np; p++) begin
            for (int b = 0; b < nb; b++) begin
                if (b < DEPTH) begin
                    exp_q.push_back({b == nb - 1, model_mem[b]});
                end else begin
                    exp_q.push_back({b == nb - 1, {4{s}}});
                    s = lfsr_adv(s);
                end
            end
        end
        seen = 0; first_cyc = -1; last_cyc = -1;
        @(negedge clk);
        cfg_bytes = bytes; cfg_delay = 16'(dly); cfg_passes = 8'(passes); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (!m_tvalid && !done) begin
            if (disturb && cnt == 1) begin
                wr_en = 1'b1; wr_addr = '0; wr_data = 128'hDEAD; start = 1'b1;
                cfg_bytes = 32'h40; cfg_passes = 8'd4;
            end
            @(negedge clk);
            wr_en = 1'b0; start = 1'b0;
            cnt++;
        end
        check(cnt == dly, {tag, " R3 start delay"}, 128'(cnt), 128'(dly));
        while (!done) @(negedge clk);
        #4;
        check(exp_q.size() == 0, {tag, " R4/R5 all beats sent"}, 128'(exp_q.size()), 0);
        check(seen == nb * np, {tag, " R5 beat count"}, 128'(seen), 128'(nb * np));
        if (seen == 0) begin
            check(latency == 0, {tag, " R11 latency"}, 128'(latency), 0);
        end else begin
            check(latency == 32'(last_cyc - first_cyc), {tag, " R9 latency"},
                  128'(latency), 128'(last_cyc - first_cyc));
            if (stall_mode == 0)
                check(latency == 32'(seen - 1), {tag, " R9 unstalled latency"},
                      128'(latency), 128'(seen - 1));
        end
        repeat (3) @(negedge clk);
        check(done == 1'b1 && !busy, {tag, " R10 done holds"}, {busy, done}, 2'b01);
        check(latency == (seen == 0 ? 0 : 32'(last_cyc - first_cyc)), {tag, " R10 latency holds"},
              128'(latency), 128'(seen == 0 ? 0 : last_cyc - first_cyc));
    endtask

    initial begin
        m_tready = 1'b1;
        repeat (3) @(negedge clk);
        check(!m_tvalid && !done && !busy, "R1 reset outputs", {m_tvalid, done, busy}, 0);
        check(latency == 0, "R1 reset latency", 128'(latency), 0);
        rst_n = 1'b1;
        preload(1);

        stall_mode = 0;
        run(32'd16 * 5 + 32'd7, 3, 1, 1'b0, "T_basic");          // R4 low bits ignored
        stall_mode = 1;
        run(32'd16 * 4, 0, 3, 1'b0, "T_replay_stall");            // R5, R8
        stall_mode = 2;
        run(32'd16 * (DEPTH + 3), 2, 2, 1'b0, "T_pad_boundary"); // R7
        stall_mode = 0;
        run(32'd16 * 2, 1, 0, 1'b0, "T_passes_zero");             // R5
        run(32'd16, 0, 1, 1'b0, "T_single_beat");                 // R9
        run(32'd8, 2, 1, 1'b0, "T_empty");                        // R11
        run(32'd16 * 3, 4, 1, 1'b1, "T_busy_ignore");             // R12
        run(32'd16, 0, 1, 1'b0, "T_after_ignore R12");            // R12 address 0 intact
        preload(2);                                               // R2 rewrite when idle
        stall_mode = 1;
        run(32'd16 * 6, 0, 2, 1'b0, "T_reload R2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule